// File: doc/BRIEF.md
# Two-Dimensional Parity Encoder and Single-Bit Corrector

This block protects a square block of N×N data bits with 2N check bits. The data word is treated as a grid. Each row gets one even-parity bit and each column gets one even-parity bit. It has two independent streaming channels.

The encode channel takes a data block and returns the 2N check bits, which the surrounding storage keeps next to the data. The check channel takes a data block and its stored check bits, and recomputes both parity vectors. Each recomputed vector is XORed with the stored one to give a row mismatch vector and a column mismatch vector.

The two mismatch vectors are classified as follows:

- A lone failing row together with a lone failing column points at one flipped data bit, which is inverted on the way out.
- A lone mismatch in only one of the two vectors means a check bit was hit. The data is passed through untouched.
- Any other nonzero pattern is reported as uncorrectable.

Both channels use valid/ready handshakes and one output register. A transfer happens on a rising clock edge where valid and ready are both high. An accepted item appears on the output one cycle later.

Back-pressure rules:

- While an output is valid and not taken, it holds its value and the matching input ready stays low.
- An input is ready whenever its output register is empty or is being drained in the same cycle.

Top module: `rcp_corrector`

## Requirements
- R1: Bit r*N+c of a data block is row r, column c. In a check word, bit r is the even parity of row r and bit N+c is the even parity of column c, so that each group XORed with its parity bit gives 0.
- R2: The encode channel presents the check word of an accepted data block on enc_out_chk with enc_out_valid high in the cycle after acceptance.
- R3: A checked block whose stored check bits match the recomputed ones is output unchanged, with both flags low.
- R4: When exactly one data bit differs from the block that was encoded, the output holds the original block, dec_out_corr is 1 and dec_out_uncorr is 0.
- R5: When exactly one check bit (row or column) is wrong and the data is intact, the data is output unchanged, dec_out_corr is 1 and dec_out_uncorr is 0.
- R6: Two flipped data bits, or two flipped row check bits, give dec_out_uncorr 1, dec_out_corr 0 and the received data unchanged. The two flags are never both high.
- R7: A block accepted on the check channel appears with dec_out_valid high in the following cycle.
- R8: While an output is valid and its ready is low, the output data and flags hold and the channel's input ready is low.
- R9: During reset both output valids are low.
- R10: The two channels operate independently, and both may accept and deliver in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enc_in_valid | input | 1 | Encode request valid |
| enc_in_ready | output | 1 | Encode channel can accept |
| enc_in_data | input | N*N | Data block to encode |
| enc_out_valid | output | 1 | Check word valid |
| enc_out_ready | input | 1 | Consumer takes check word |
| enc_out_chk | output | 2N | Row parities (low N bits), column parities (high N bits) |
| dec_in_valid | input | 1 | Check request valid |
| dec_in_ready | output | 1 | Check channel can accept |
| dec_in_data | input | N*N | Data block read from storage |
| dec_in_chk | input | 2N | Stored check word |
| dec_out_valid | output | 1 | Checked result valid |
| dec_out_ready | input | 1 | Consumer takes result |
| dec_out_data | output | N*N | Data block, corrected when possible |
| dec_out_corr | output | 1 | A single data or check bit error was found |
| dec_out_uncorr | output | 1 | The mismatch pattern cannot be corrected |

## Verification
The encode handshake and the check handshake can land on the same clock edge. The bench forks an encode of a block and a check of a corrupted copy of that block, so both channels are accepted together. Both results are then judged against independent expected queues. A second overlap is a held output during back-pressure while a new request is waiting at the input. This is provoked by forcing ready low, and judged by requiring stable outputs and a low input ready until ready returns.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
  typedef enum logic [1:0] {
    CLS_CLEAN = 2'd0,
    CLS_DATA  = 2'd1,
    CLS_CHECK = 2'd2,
    CLS_MULTI = 2'd3
  } err_class_t;
endpackage

// File: rtl/rcp_parity.sv
module rcp_parity #(
  parameter int N = 8
) (
  input  logic [N*N-1:0] data,
  output logic [N-1:0]   row_par,
  output logic [N-1:0]   col_par
);
  for (genvar r = 0; r < N; r++) begin : g_row
    assign row_par[r] = ^data[r*N +: N];
  end
  for (genvar c = 0; c < N; c++) begin : g_col
    logic [N-1:0] bits;
    for (genvar r = 0; r < N; r++) begin : g_bit
      assign bits[r] = data[r*N + c];
    end
    assign col_par[c] = ^bits;
  end
endmodule

// File: rtl/rcp_classify.sv
module rcp_classify
  import rcp_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]   row_syn,
  input  logic [N-1:0]   col_syn,
  output logic [N*N-1:0] flip_mask,
  output err_class_t     cls
);
  logic row_zero, col_zero, row_one, col_one;

  assign row_zero = (row_syn == '0);
  assign col_zero = (col_syn == '0);
  assign row_one  = !row_zero && ((row_syn & (row_syn - 1'b1)) == '0);
  assign col_one  = !col_zero && ((col_syn & (col_syn - 1'b1)) == '0);

  always_comb begin
    if (row_zero && col_zero)                             cls = CLS_CLEAN;
    else if (row_one && col_one)                          cls = CLS_DATA;
    else if ((row_one && col_zero) || (row_zero && col_one)) cls = CLS_CHECK;
    else                                                  cls = CLS_MULTI;
  end

  for (genvar r = 0; r < N; r++) begin : g_mr
    for (genvar c = 0; c < N; c++) begin : g_mc
      assign flip_mask[r*N + c] = (cls == CLS_DATA) && row_syn[r] && col_syn[c];
    end
  end
endmodule

// File: rtl/rcp_stage.sv
module rcp_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end
endmodule

// File: rtl/rcp_corrector.sv
module rcp_corrector
  import rcp_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enc_in_valid,
  output logic             enc_in_ready,
  input  logic [N*N-1:0]   enc_in_data,
  output logic             enc_out_valid,
  input  logic             enc_out_ready,
  output logic [2*N-1:0]   enc_out_chk,
  input  logic             dec_in_valid,
  output logic             dec_in_ready,
  input  logic [N*N-1:0]   dec_in_data,
  input  logic [2*N-1:0]   dec_in_chk,
  output logic             dec_out_valid,
  input  logic             dec_out_ready,
  output logic [N*N-1:0]   dec_out_data,
  output logic             dec_out_corr,
  output logic             dec_out_uncorr
);
  localparam int NB = N * N;
  localparam int CW = 2 * N;
  localparam int DW = NB + 2;

  // encode channel
  logic [N-1:0] enc_row, enc_col;
  rcp_parity #(.N(N)) u_enc_par (.data(enc_in_data), .row_par(enc_row), .col_par(enc_col));

  rcp_stage #(.W(CW)) u_enc_stage (
    .clk(clk), .rst(rst),
    .in_valid(enc_in_valid), .in_ready(enc_in_ready), .in_data({enc_col, enc_row}),
    .out_valid(enc_out_valid), .out_ready(enc_out_ready), .out_data(enc_out_chk)
  );

  // check channel
  logic [N-1:0]  dec_row, dec_col, row_syn, col_syn;
  logic [NB-1:0] flip_mask;
  err_class_t    cls;
  logic          corr_c, uncorr_c;

  rcp_parity #(.N(N)) u_dec_par (.data(dec_in_data), .row_par(dec_row), .col_par(dec_col));

  assign row_syn = dec_row ^ dec_in_chk[N-1:0];
  assign col_syn = dec_col ^ dec_in_chk[CW-1:N];

  rcp_classify #(.N(N)) u_cls (
    .row_syn(row_syn), .col_syn(col_syn), .flip_mask(flip_mask), .cls(cls)
  );

  assign corr_c   = (cls == CLS_DATA) || (cls == CLS_CHECK);
  assign uncorr_c = (cls == CLS_MULTI);

  logic [DW-1:0] dec_pack;
  rcp_stage #(.W(DW)) u_dec_stage (
    .clk(clk), .rst(rst),
    .in_valid(dec_in_valid), .in_ready(dec_in_ready),
    .in_data({dec_in_data ^ flip_mask, corr_c, uncorr_c}),
    .out_valid(dec_out_valid), .out_ready(dec_out_ready), .out_data(dec_pack)
  );

  assign dec_out_data   = dec_pack[DW-1:2];
  assign dec_out_corr   = dec_pack[1];
  assign dec_out_uncorr = dec_pack[0];
endmodule

// File: rtl/rcp_corrector_chk.sv
module rcp_corrector_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           enc_in_valid,
  input logic           enc_in_ready,
  input logic           enc_out_valid,
  input logic           enc_out_ready,
  input logic [2*N-1:0] enc_out_chk,
  input logic           dec_in_valid,
  input logic           dec_in_ready,
  input logic           dec_out_valid,
  input logic           dec_out_ready,
  input logic [N*N-1:0] dec_out_data,
  input logic           dec_out_corr,
  input logic           dec_out_uncorr
);
  // R6
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    dec_out_valid |-> !(dec_out_corr && dec_out_uncorr));

  // R2
  enc_latency_chk: assert property (@(posedge clk) disable iff (rst)
    enc_in_valid && enc_in_ready |=> enc_out_valid);

  // R7
  dec_latency_chk: assert property (@(posedge clk) disable iff (rst)
    dec_in_valid && dec_in_ready |=> dec_out_valid);

  // R8
  enc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_out_chk));

  // R8
  dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_data)
      && $stable(dec_out_corr) && $stable(dec_out_uncorr));

  // R8
  dec_stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
    dec_out_valid && !dec_out_ready |-> !dec_in_ready);

  // R9
  reset_empty_chk: assert property (@(posedge clk)
    rst |=> !enc_out_valid && !dec_out_valid);
endmodule

bind rcp_corrector rcp_corrector_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst),
  .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready),
  .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready), .enc_out_chk(enc_out_chk),
  .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready),
  .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready), .dec_out_data(dec_out_data),
  .dec_out_corr(dec_out_corr), .dec_out_uncorr(dec_out_uncorr)
);

// File: tb/sim_rcp_corrector.sv
module sim_rcp_corrector;
  localparam int N  = 8;
  localparam int NB = N * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc_in_valid = 1'b0, enc_in_ready, enc_out_valid, enc_out_ready;
  logic [NB-1:0] enc_in_data = '0;
  logic [2*N-1:0] enc_out_chk;
  logic dec_in_valid = 1'b0, dec_in_ready, dec_out_valid, dec_out_ready;
  logic [NB-1:0] dec_in_data = '0, dec_out_data;
  logic [2*N-1:0] dec_in_chk = '0;
  logic dec_out_corr, dec_out_uncorr;

  int checks = 0;
  int fails  = 0;
  int bp_mode = 0;  // 0 always ready, 1 random, 2 stalled
  bit done = 0;

  logic [2*N-1:0] enc_q[$];
  string          enc_tag[$];
  logic [NB+1:0]  dec_q[$];
  string          dec_tag[$];

  always #5 clk = ~clk;

  rcp_corrector #(.N(N)) u0 (.*);

  // R1: even parity per row (bit r) and per column (bit N+c)
  function automatic logic [2*N-1:0] ref_chk(input logic [NB-1:0] d);
    logic [2*N-1:0] k = '0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        k[r]   = k[r]   ^ d[r*N + c];
        k[N+c] = k[N+c] ^ d[r*N + c];
      end
    return k;
  endfunction

  function automatic logic [NB-1:0] rand_block();
    logic [NB-1:0] d;
    for (int i = 0; i < NB; i++) d[i] = 1'($urandom % 2);
    return d;
  endfunction

  task automatic check(input string req, input logic [NB+1:0] act, input logic [NB+1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    enc_out_ready = 1'b1;
    dec_out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      case (bp_mode)
        0: begin enc_out_ready = 1'b1; dec_out_ready = 1'b1; end
        1: begin enc_out_ready = ($urandom % 3) != 0; dec_out_ready = ($urandom % 3) != 0; end
        default: begin enc_out_ready = 1'b0; dec_out_ready = 1'b0; end
      endcase
    end
  end

  // monitors: a transfer seen at the falling edge completes at the next rising edge
  initial forever begin
    @(negedge clk);
    if (!rst && enc_out_valid && enc_out_ready) begin
      if (enc_q.size() == 0) check("R2 unexpected", {{(NB-2*N+2){1'b0}}, enc_out_chk}, '0);
      else check(enc_tag.pop_front(), {{(NB-2*N+2){1'b0}}, enc_out_chk},
                 {{(NB-2*N+2){1'b0}}, enc_q.pop_front()});
    end
    if (!rst && dec_out_valid && dec_out_ready) begin
      if (dec_q.size() == 0) check("R7 unexpected", {dec_out_data, dec_out_corr, dec_out_uncorr}, '0);
      else check(dec_tag.pop_front(), {dec_out_data, dec_out_corr, dec_out_uncorr}, dec_q.pop_front());
    end
  end

  task automatic send_enc(input logic [NB-1:0] d, input string tag);
    @(negedge clk);
    enc_in_valid = 1'b1;
    enc_in_data  = d;
    while (!enc_in_ready) @(negedge clk);
    enc_q.push_back(ref_chk(d));
    enc_tag.push_back(tag);
    @(posedge clk); #1;
    enc_in_valid = 1'b0;
  endtask

  // kind: 0 clean, 1 one data bit, 2 one check bit, 3 two data bits, 4 two row check bits
  task automatic send_dec(input logic [NB-1:0] d, input int kind, input string tag);
    logic [NB-1:0]  rd = d;
    logic [2*N-1:0] k  = ref_chk(d);
    int i = $urandom % NB;
    int j = (i + 1 + ($urandom % (NB - 1))) % NB;
    int a = $urandom % N;
    int b = (a + 1 + ($urandom % (N - 1))) % N;
    case (kind)
      1: rd[i] = ~rd[i];
      2: k[$urandom % (2*N)] ^= 1'b1;
      3: begin rd[i] = ~rd[i]; rd[j] = ~rd[j]; end
      4: begin k[a] = ~k[a]; k[b] = ~k[b]; end
      default: ;
    endcase
    @(negedge clk);
    dec_in_valid = 1'b1;
    dec_in_data  = rd;
    dec_in_chk   = k;
    while (!dec_in_ready) @(negedge clk);
    case (kind)
      0: dec_q.push_back({d, 1'b0, 1'b0});
      1, 2: dec_q.push_back({d, 1'b1, 1'b0});
      default: dec_q.push_back({rd, 1'b0, 1'b1});
    endcase
    dec_tag.push_back(tag);
    @(posedge clk); #1;
    dec_in_valid = 1'b0;
  endtask

  function automatic string kind_tag(input int kind);
    case (kind)
      0: return "R3 clean";
      1: return "R4 data bit";
      2: return "R5 check bit";
      default: return "R6 uncorrectable";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] held;
    logic          wrong;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9
    check("R9 reset valids", {enc_out_valid, dec_out_valid}, '0);
    rst = 1'b0;

    // R1 / R2 directed patterns
    send_enc('0, "R1 zeros");
    @(negedge clk);
    check("R2 latency", {{(NB+1){1'b0}}, enc_out_valid}, 1);
    send_enc('1, "R1 ones");
    send_enc({{(NB-1){1'b0}}, 1'b1}, "R1 corner bit");
    send_enc({NB/2{2'b01}}, "R1 stripes");

    // R7 latency
    send_dec(rand_block(), 0, "R3 clean");
    @(negedge clk);
    check("R7 latency", {{(NB+1){1'b0}}, dec_out_valid}, 1);

    // R3..R6 with random back-pressure
    bp_mode = 1;
    for (int n = 0; n < 60; n++) begin
      int kind = n % 5;
      send_dec(rand_block(), kind, kind_tag(kind));
    end
    for (int n = 0; n < 10; n++) send_enc(rand_block(), "R1 random");

    // R8 stall
    repeat (4) @(posedge clk);
    bp_mode = 2;
    repeat (8) @(posedge clk);
    send_dec(rand_block(), 1, "R4 after stall");
    @(negedge clk);
    held  = dec_out_data;
    wrong = 1'b0;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      if (dec_out_data !== held || !dec_out_valid || dec_in_ready) wrong = 1'b1;
    end
    check("R8 hold under stall", {{(NB+1){1'b0}}, wrong}, '0);

    // R10 both channels in the same cycle
    bp_mode = 0;
    repeat (3) @(posedge clk);
    for (int n = 0; n < 20; n++) begin
      logic [NB-1:0] d = rand_block();
      fork
        send_enc(d, "R10 encode side");
        send_dec(d, 1, "R10 check side");
      join
    end

    repeat (20) @(posedge clk);
    check("R10 drained", {{(NB-14){1'b0}}, 8'(enc_q.size()), 8'(dec_q.size())}, '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule